// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one phase-locked loop without ever handing a half-configured clock to the logic downstream. A single start pulse carries a new set of divisors: the reference divider NR, the feedback multiplier NF and the output divider NO. The block first checks these against the loop's legal operating range. An illegal set is turned away with an error flag and nothing else moves. A legal set starts a fixed ordering. The clock mode is switched to the slow bypass source. The loop's reset is raised. The control fields are written. Reset is held for ten microseconds, counted in core cycles. Then reset is released, the block waits for the lock indication and, once lock is seen, returns the mode to the normal loop output.

The control fields come out as four 16-bit control words, the form a neighbouring register file or analog wrapper decodes. If lock never arrives within a parameterised number of cycles, the block flags an error, leaves the mode on the bypass clock and goes back to idle. `busy` is high for the whole ordering and `done` pulses once when it ends successfully.

Top module: `pll_reprog_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `err` are 0, `pll_mode` is 0 (slow) and all four control words are 0.
- R2: A start is rejected when any of these holds: NR outside 1..64, NF outside 2..8192, NO outside 1..16, NO odd and not 1, VCO = REF_KHZ*NF/NR outside 440000..2200000 kHz, or VCO/NO outside 27500..2200000 kHz (bounds inclusive, compared exactly). On rejection `err` is 1 in the cycle after the start, `busy` stays 0, and the mode and control words keep their previous values.
- R3: On an accepted start, in the next cycle `busy` is 1 and `pll_mode` is 0. The reset bit (bit 5 of word 3) rises one cycle later. The divider fields change one cycle after that, and not before.
- R4: Word 0 holds NR-1 in bits 13:8 and NO-1 in bits 3:0. Word 1 holds NF-1 in bits 12:0. Word 2 holds NF/2-1 (integer halving) in bits 11:0. All other bits are 0, and the fields change only while the reset bit is 1.
- R5: The reset bit stays at 1 for exactly 10*CLK_MHZ+1 cycles, so the new fields sit under reset for 10*CLK_MHZ cycles before release.
- R6: After release, `pll_mode` becomes 1 only in the cycle after `pll_lock` is sampled high. In that same cycle `busy` falls and `done` is 1 for exactly one cycle.
- R7: If `pll_lock` stays low for LOCK_TIMEOUT cycles after release, then `err` rises exactly LOCK_TIMEOUT cycles after release, `busy` falls, `done` stays 0 and `pll_mode` stays 0.
- R8: A start while `busy` is 1 is ignored: the running ordering finishes with its own divisors and timing.
- R9: An accepted start clears a previously raised `err` in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to reprogram |
| div_nr | input | 7 | Requested reference divider NR |
| div_nf | input | 14 | Requested feedback multiplier NF |
| div_no | input | 5 | Requested output divider NO |
| pll_lock | input | 1 | Lock indication from the loop |
| pll_con0 | output | 16 | Control word 0: NR-1 at 13:8, NO-1 at 3:0 |
| pll_con1 | output | 16 | Control word 1: NF-1 at 12:0 |
| pll_con2 | output | 16 | Control word 2: bandwidth value NF/2-1 at 11:0 |
| pll_con3 | output | 16 | Control word 3: loop reset at bit 5 |
| pll_mode | output | 2 | Clock mode: 0 slow bypass, 1 normal |
| busy | output | 1 | Ordering in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Illegal divisors or lock timeout |

## Verification
The bench targets the exact edges of the legal range: a VCO of exactly 440 MHz and 2200 MHz, and an output of exactly 27.5 MHz with NO=16. A checker that used strict bounds or truncating division would reject these. Just beyond them it uses NO=3, NR=0, NO=0, NR=65 and NO=18; a checker that missed one of these would start an ordering where `err` is expected. It counts the reset-high cycles and the cycles from release to the timeout error, so an off-by-one in the hold or the timeout load shows up as a wrong count. It injects a second start partway through the hold, which a design that re-latched divisors while busy would turn into wrong control words.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  // control field geometry, fixed by the decoder of the control words
  localparam int WORD_W  = 16;
  localparam int NR_W    = 6;
  localparam int NF_W    = 13;
  localparam int NO_W    = 4;
  localparam int BW_W    = 12;
  localparam int NR_LSB  = 8;
  localparam int RST_BIT = 5;

  localparam logic [1:0] MODE_SLOW = 2'd0;
  localparam logic [1:0] MODE_NORM = 2'd1;

  // operating range of the loop, in kHz
  localparam longint VCO_MIN_KHZ = 440000;
  localparam longint VCO_MAX_KHZ = 2200000;
  localparam longint OUT_MIN_KHZ = 27500;
  localparam longint OUT_MAX_KHZ = 2200000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET_ON,
    ST_PROGRAM,
    ST_HOLD,
    ST_LOCK_WAIT
  } seq_state_t;
endpackage

// File: rtl/pll_div_legal.sv
module pll_div_legal
  import pll_seq_pkg::*;
#(
  parameter int REF_KHZ = 24000,
  parameter int NR_IW   = NR_W + 1,
  parameter int NF_IW   = NF_W + 1,
  parameter int NO_IW   = NO_W + 1
) (
  input  logic [NR_IW-1:0] nr,
  input  logic [NF_IW-1:0] nf,
  input  logic [NO_IW-1:0] no,
  output logic             legal
);
  localparam int MW = 56;
  localparam logic [NR_IW-1:0] NR_MAX = NR_IW'(2 ** NR_W);
  localparam logic [NF_IW-1:0] NF_MAX = NF_IW'(2 ** NF_W);
  localparam logic [NO_IW-1:0] NO_MAX = NO_IW'(2 ** NO_W);

  logic          nr_ok, nf_ok, no_ok, vco_ok, out_ok;
  logic [MW-1:0] vco_scaled, nr_x, div_x;

  // ranges are compared cross-multiplied, so no divider is needed
  always_comb begin
    nr_ok      = (nr != '0) && (nr <= NR_MAX);
    nf_ok      = (nf >= NF_IW'(2)) && (nf <= NF_MAX);
    no_ok      = (no != '0) && (no <= NO_MAX) && ((no == NO_IW'(1)) || !no[0]);
    vco_scaled = MW'(REF_KHZ) * MW'(nf);
    nr_x       = MW'(nr);
    div_x      = nr_x * MW'(no);
    vco_ok     = (vco_scaled >= MW'(VCO_MIN_KHZ) * nr_x) &&
                 (vco_scaled <= MW'(VCO_MAX_KHZ) * nr_x);
    out_ok     = (vco_scaled >= MW'(OUT_MIN_KHZ) * div_x) &&
                 (vco_scaled <= MW'(OUT_MAX_KHZ) * div_x);
    legal      = nr_ok && nf_ok && no_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int REF_KHZ      = 24000,
  parameter int CLK_MHZ      = 200,
  parameter int LOCK_TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NR_W:0]     div_nr,
  input  logic [NF_W:0]     div_nf,
  input  logic [NO_W:0]     div_no,
  input  logic              pll_lock,
  output logic [WORD_W-1:0] pll_con0,
  output logic [WORD_W-1:0] pll_con1,
  output logic [WORD_W-1:0] pll_con2,
  output logic [WORD_W-1:0] pll_con3,
  output logic [1:0]        pll_mode,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int HOLD_CYC = 10 * CLK_MHZ;
  localparam int CNT_MAX  = (HOLD_CYC > LOCK_TIMEOUT) ? HOLD_CYC : LOCK_TIMEOUT;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LOCK_LOAD = CW'(LOCK_TIMEOUT - 1);

  seq_state_t state;
  logic [NR_W:0]   nr_q;
  logic [NF_W:0]   nf_q;
  logic [NO_W:0]   no_q;
  logic [NR_W-1:0] nr_f;
  logic [NF_W-1:0] nf_f;
  logic [NO_W-1:0] no_f;
  logic [BW_W-1:0] bw_f;
  logic            rst_bit;
  logic            legal;
  logic            tmr_load, tmr_expired;
  logic [CW-1:0]   tmr_val;
  logic [NR_W:0]   nr_m1;
  logic [NF_W:0]   nf_m1, bw_m1;
  logic [NO_W:0]   no_m1;

  pll_div_legal #(
    .REF_KHZ(REF_KHZ), .NR_IW(NR_W + 1), .NF_IW(NF_W + 1), .NO_IW(NO_W + 1)
  ) u_legal (
    .nr(div_nr), .nf(div_nf), .no(div_no), .legal(legal)
  );

  // one counter serves both the reset hold and the lock timeout
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = HOLD_LOAD;
    if (state == ST_PROGRAM) begin
      tmr_load = 1'b1;
    end else if (state == ST_HOLD && tmr_expired) begin
      tmr_load = 1'b1;
      tmr_val  = LOCK_LOAD;
    end
  end

  pll_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  always_comb begin
    nr_m1 = nr_q - 1'b1;
    nf_m1 = nf_q - 1'b1;
    no_m1 = no_q - 1'b1;
    bw_m1 = (nf_q >> 1) - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      nr_q     <= '0;
      nf_q     <= '0;
      no_q     <= '0;
      nr_f     <= '0;
      nf_f     <= '0;
      no_f     <= '0;
      bw_f     <= '0;
      rst_bit  <= 1'b0;
      pll_mode <= MODE_SLOW;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (legal) begin
              nr_q     <= div_nr;
              nf_q     <= div_nf;
              no_q     <= div_no;
              pll_mode <= MODE_SLOW;
              busy     <= 1'b1;
              err      <= 1'b0;
              state    <= ST_RESET_ON;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_RESET_ON: begin
          rst_bit <= 1'b1;
          state   <= ST_PROGRAM;
        end
        ST_PROGRAM: begin
          nr_f  <= nr_m1[NR_W-1:0];
          nf_f  <= nf_m1[NF_W-1:0];
          no_f  <= no_m1[NO_W-1:0];
          bw_f  <= bw_m1[BW_W-1:0];
          state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_expired) begin
            rst_bit <= 1'b0;
            state   <= ST_LOCK_WAIT;
          end
        end
        ST_LOCK_WAIT: begin
          if (pll_lock) begin
            pll_mode <= MODE_NORM;
            busy     <= 1'b0;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else if (tmr_expired) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pll_con0 = '0;
    pll_con0[NR_LSB +: NR_W] = nr_f;
    pll_con0[0 +: NO_W]      = no_f;
    pll_con1 = '0;
    pll_con1[0 +: NF_W]      = nf_f;
    pll_con2 = '0;
    pll_con2[0 +: BW_W]      = bw_f;
    pll_con3 = '0;
    pll_con3[RST_BIT]        = rst_bit;
  end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk
  import pll_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pll_lock,
  input logic [WORD_W-1:0] pll_con0,
  input logic [WORD_W-1:0] pll_con1,
  input logic [WORD_W-1:0] pll_con2,
  input logic [WORD_W-1:0] pll_con3,
  input logic [1:0]        pll_mode,
  input logic              busy,
  input logic              done,
  input logic              err
);
  assert_normal_after_lock_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_mode[0]) |-> $past(pll_lock));

  assert_reset_in_slow_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_con3[RST_BIT]) |-> (pll_mode == MODE_SLOW) && busy);

  assert_fields_under_reset_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable({pll_con0, pll_con1, pll_con2}) |-> pll_con3[RST_BIT]);

  assert_done_ends_run_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && (pll_mode == MODE_NORM));

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !busy && !done);

  assert_release_slow_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_con3[RST_BIT]) |-> busy && (pll_mode == MODE_SLOW));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (.*);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
  localparam int REF_KHZ  = 24000;
  localparam int CLK_MHZ  = 200;
  localparam int LOCK_TO  = 4096;
  localparam int HOLD     = 10 * CLK_MHZ;
  localparam int LOCK_DLY = 20;
  localparam int NVEC     = 12;

  // {legal, nr, nf, no}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1, 7'd1,  14'd75,   5'd1},   // vco 1800
    {1'b1, 7'd2,  14'd99,   5'd2},   // vco 1188
    {1'b0, 7'd1,  14'd50,   5'd3},   // odd NO
    {1'b1, 7'd9,  14'd400,  5'd2},   // vco 1066.7
    {1'b0, 7'd1,  14'd18,   5'd1},   // vco 432 low
    {1'b1, 7'd3,  14'd55,   5'd16},  // vco 440, out 27.5 exact
    {1'b0, 7'd3,  14'd276,  5'd1},   // vco 2208 high
    {1'b1, 7'd3,  14'd275,  5'd1},   // vco 2200 exact
    {1'b0, 7'd0,  14'd75,   5'd1},   // NR zero
    {1'b0, 7'd1,  14'd75,   5'd0},   // NO zero
    {1'b0, 7'd65, 14'd1300, 5'd1},   // NR too large
    {1'b0, 7'd1,  14'd75,   5'd18}   // NO too large
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  nr_i = '0;
  logic [13:0] nf_i = '0;
  logic [4:0]  no_i = '0;
  logic        pll_lock;
  logic        lock_en = 1'b1;
  logic [15:0] con0, con1, con2, con3;
  logic [1:0]  mode;
  logic        busy, done, err;
  int          checks = 0;
  int          errors = 0;
  int          lk_cnt;

  always #2.5 clk = ~clk;

  pll_reprog_seq #(.REF_KHZ(REF_KHZ), .CLK_MHZ(CLK_MHZ), .LOCK_TIMEOUT(LOCK_TO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .div_nr(nr_i), .div_nf(nf_i), .div_no(no_i),
    .pll_lock(pll_lock), .pll_con0(con0), .pll_con1(con1), .pll_con2(con2),
    .pll_con3(con3), .pll_mode(mode), .busy(busy), .done(done), .err(err)
  );

  // loop model: lock appears LOCK_DLY cycles after reset release
  always @(posedge clk) begin
    if (rst || con3[5] || !lock_en) begin
      lk_cnt   <= 0;
      pll_lock <= 1'b0;
    end else if (lk_cnt == LOCK_DLY) begin
      pll_lock <= 1'b1;
    end else begin
      lk_cnt <= lk_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [6:0] nr, input logic [13:0] nf, input logic [4:0] no,
                     input bit legal, input bit lock_ok, input bit poke);
    logic [47:0] prev_w, exp_w;
    logic [1:0]  prev_mode;
    int rst_hi, post, n;
    bit  slow_ok;
    prev_w    = {con0, con1, con2};
    prev_mode = mode;
    exp_w     = {2'b0, 6'(nr - 7'd1), 4'b0, 4'(no - 5'd1),
                 3'b0, 13'(nf - 14'd1),
                 4'b0, 12'((nf >> 1) - 14'd1)};
    lock_en = lock_ok;
    @(negedge clk);
    nr_i = nr; nf_i = nf; no_i = no; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!legal) begin
      chk(err == 1'b1, "R2 err after illegal start", err, 1);
      chk(busy == 1'b0 && mode == prev_mode && {con0, con1, con2} == prev_w,
          "R2 nothing changes on rejection", {con0, con1, con2}, prev_w);
      return;
    end
    chk(busy && mode == 2'd0 && !con3[5] && {con0, con1, con2} == prev_w,
        "R3 slow mode first", {busy, mode, con3[5]}, 3'b100);
    chk(err == 1'b0, "R9 err cleared by accepted start", err, 0);
    @(negedge clk);
    chk(con3 == 16'h0020 && {con0, con1, con2} == prev_w,
        "R3 reset before fields", con3, 16'h0020);
    @(negedge clk);
    chk({con0, con1, con2} == exp_w, "R4 field encoding", {con0, con1, con2}, exp_w);
    rst_hi = 2; post = 0; n = 0; slow_ok = 1;
    while (busy && n < 20000) begin
      n++;
      if (poke && n == 50) begin
        nr_i = 7'd9; nf_i = 14'd400; no_i = 5'd2; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (busy && con3[5]) rst_hi++;
      if (busy && !con3[5]) post++;
      if (busy && mode != 2'd0) slow_ok = 0;
    end
    chk(n < 20000, "R6 run terminates", n, 0);
    chk(rst_hi == HOLD + 1, "R5 reset hold length", rst_hi, HOLD + 1);
    chk(slow_ok, "R6 slow until lock", slow_ok, 1);
    if (lock_ok) begin
      chk(done && mode == 2'd1 && !err, "R6 normal mode and done", {done, mode, err}, 4'b1010);
      @(negedge clk);
      chk(done == 1'b0, "R6 done is one pulse", done, 0);
    end else begin
      chk(err && mode == 2'd0 && !done, "R7 timeout error stays slow", {err, mode, done}, 4'b1000);
      chk(post == LOCK_TO, "R7 timeout length", post, LOCK_TO);
    end
    if (poke)
      chk({con0, con1, con2} == exp_w, "R8 start while busy ignored", {con0, con1, con2}, exp_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && mode == 2'd0 && con0 == 0 && con1 == 0 && con2 == 0 && con3 == 0,
        "R1 reset state", {busy, done, err, mode}, 0);
    for (int i = 0; i < NVEC; i++)
      run(VEC[i][25:19], VEC[i][18:5], VEC[i][4:0], VEC[i][26], 1'b1, 1'b0);
    run(7'd2, 14'd99, 5'd2, 1'b1, 1'b1, 1'b1);   // R8 poke during hold
    run(7'd1, 14'd75, 5'd1, 1'b1, 1'b0, 1'b0);   // R7 no lock
    run(7'd3, 14'd275, 5'd1, 1'b1, 1'b1, 1'b0);  // R9 clears timeout error
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule